// File: doc/BRIEF.md
# Write-Protect Flag Manager

This block keeps the write-protect state of a small serial memory and gives every protection-related answer the bus engine needs. The engine decodes each device-address byte and presents it together with phase strobes: device byte received, later byte received, WP strobe, and STOP. The block replies with an acknowledge decision for each phase. It also holds two software protection flags. One is a one-time permanent flag. The other is a reversible flag that can only be reached while a high-voltage detector on the lowest strap pin reports the overdrive level.

Protection commands use their own device-address preamble. A read in that space returns no data and reports the flag state through the acknowledge bit. A set or clear command carries one dummy address byte and one dummy data byte. It takes effect at STOP, where the block issues a one-cycle request to the write sequencer together with an operation code. For any target address, a combinational output tells the sequencer whether a write there is blocked. That output combines the software flags, which guard only the lower half, with the WP level sampled for the current command, which guards everything.

Top module: `wp_guard`

## Requirements
- R1: A device byte whose upper nibble is 1010 is acknowledged exactly when its bits [3:1] equal the strap levels {A2,A1,A0}, for both R/W values (bit 0).
- R2: With the high-voltage input low, a device byte with upper nibble 0110 and bits [3:1] equal to the straps is acknowledged only while the permanent flag is clear, for both R/W values. So a permanent-flag read answers NoACK when the flag is set.
- R3: With the high-voltage input high, a 0110 device byte is accepted as a reversible command only when strap A2 is low and bits [3:1] equal {A2, A1, 1}. Strap A1 low selects set and A1 high selects clear. A write is acknowledged, and a read is acknowledged only while the reversible flag is clear. Every other upper nibble is never acknowledged.
- R4: An acknowledged protection write whose first data byte was acknowledged produces, in the cycle after STOP, a one-cycle flag_req with flag_op 00 (set permanent), 01 (set reversible) or 10 (clear reversible), and the flag changes at that moment.
- R5: If WP is high at the WP strobe, the next data byte is answered NoACK. A protection write rejected this way makes no request and changes no flag.
- R6: addr_prot is high for a target address with MSB 0 while either flag is set. An address with MSB 1 is never blocked by the flags. While a WP level of 1 is held for the current command, every address is blocked.
- R7: The permanent flag, once set, stays set. Further permanent set commands are answered NoACK, and clearing the reversible flag leaves lower-half protection in place.
- R8: If the high-voltage input drops at any point between the device byte and STOP of a reversible write, the command makes no request and the reversible flag keeps its value.
- R9: The address byte of any write is acknowledged. Memory-write data bytes are acknowledged while the sampled WP is low. A protection write acknowledges only its first data byte.
- R10: After reset both flags are clear and dev_ack, data_ack, flag_req and addr_prot are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dev_valid | input | 1 | Device-address byte received (one-cycle strobe) |
| dev_byte | input | 8 | Decoded device-address byte: preamble, select bits, R/W |
| strap | input | 3 | Strap levels {A2,A1,A0} |
| a0_hv | input | 1 | High-voltage detected on strap A0 |
| wp_pin | input | 1 | Write-protect pin level |
| wp_sample | input | 1 | Strobe on the SCL falling edge before the first data byte |
| byte_done | input | 1 | A byte following the device byte was received |
| stop_evt | input | 1 | STOP condition seen |
| tgt_addr | input | ADDR_W | Memory address the sequencer wants to write |
| dev_ack | output | 1 | ACK decision for the device-address phase |
| data_ack | output | 1 | ACK decision for the latest later byte |
| flag_req | output | 1 | Request to the write sequencer for a flag write cycle |
| flag_op | output | 2 | Flag operation for flag_req |
| addr_prot | output | 1 | Target address is write-protected |

## Verification
The bench uses the default 8-bit address width. At that width, all 256 device bytes can be combined with all eight strap patterns and both high-voltage levels. The full decode space is therefore swept in three flag states: both clear, reversible set, and permanent set. With 256 target addresses, the half-boundary of the protection output is also swept exhaustively in each state, including the sampled-WP override. Directed sequences then cover the WP rejection, the extra-byte NoACK, high voltage lost mid-command, and the permanent flag's resistance to clearing.

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W = 8,
  parameter logic [3:0] MEM_PRE = 4'b1010,
  parameter logic [3:0] PROT_PRE = 4'b0110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_valid,
  input  logic [7:0]        dev_byte,
  input  logic [2:0]        strap,
  input  logic              a0_hv,
  input  logic              wp_pin,
  input  logic              wp_sample,
  input  logic              byte_done,
  input  logic              stop_evt,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              dev_ack,
  output logic              data_ack,
  output logic              flag_req,
  output logic [1:0]        flag_op,
  output logic              addr_prot
);
  typedef enum logic [2:0] {K_IDLE, K_MRD, K_MWR, K_PRD, K_PWR} kind_t;
  localparam logic [1:0] OP_SETP = 2'b00, OP_SETR = 2'b01, OP_CLRR = 2'b10;

  kind_t      kind;
  logic [1:0] op, cnt;
  logic       pswp, rswp, wp_lat, hv_ok, armed;

  wire [3:0] pre = dev_byte[7:4];
  wire [2:0] sel = dev_byte[3:1];
  wire       rw  = dev_byte[0];

  wire is_mem  = (pre == MEM_PRE) && (sel == strap);
  wire is_rev  = (pre == PROT_PRE) && a0_hv && !strap[2] && (sel == {strap[2:1], 1'b1});
  wire is_perm = (pre == PROT_PRE) && !a0_hv && (sel == strap);
  wire ack_d   = is_mem || (is_rev && (!rw || !rswp)) || (is_perm && !pswp);

  wire wp_eff  = wp_sample ? wp_pin : wp_lat;
  wire wr_kind = (kind == K_MWR) || (kind == K_PWR);
  wire dack_d  = (cnt == 2'd0) ? wr_kind :
                 (cnt == 2'd1) ? (wr_kind && !wp_eff) :
                                 ((kind == K_MWR) && !wp_eff);
  wire commit  = (kind == K_PWR) && armed && ((op == OP_SETP) || (hv_ok && a0_hv));

  assign addr_prot = wp_lat || ((pswp || rswp) && !tgt_addr[ADDR_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= K_IDLE; op <= OP_SETP; cnt <= 2'd0;
      pswp <= 1'b0; rswp <= 1'b0; wp_lat <= 1'b0; hv_ok <= 1'b0; armed <= 1'b0;
      dev_ack <= 1'b0; data_ack <= 1'b0; flag_req <= 1'b0; flag_op <= OP_SETP;
    end else begin
      flag_req <= 1'b0;
      if (!a0_hv) hv_ok <= 1'b0;
      if (wp_sample) wp_lat <= wp_pin;
      if (stop_evt) begin
        if (commit) begin
          flag_req <= 1'b1;
          flag_op  <= op;
          case (op)
            OP_SETP: pswp <= 1'b1;
            OP_SETR: rswp <= 1'b1;
            default: rswp <= 1'b0;
          endcase
        end
        kind <= K_IDLE; armed <= 1'b0; cnt <= 2'd0; wp_lat <= 1'b0;
        dev_ack <= 1'b0; data_ack <= 1'b0;
      end else if (dev_valid) begin
        dev_ack  <= ack_d;
        data_ack <= 1'b0;
        hv_ok    <= a0_hv;
        wp_lat   <= 1'b0;
        armed    <= 1'b0;
        cnt      <= 2'd0;
        op       <= is_rev ? (strap[1] ? OP_CLRR : OP_SETR) : OP_SETP;
        if (!ack_d)      kind <= K_IDLE;
        else if (is_mem) kind <= rw ? K_MRD : K_MWR;
        else             kind <= rw ? K_PRD : K_PWR;
      end else if (byte_done) begin
        data_ack <= dack_d;
        if (cnt == 2'd1 && kind == K_PWR && dack_d) armed <= 1'b1;
        if (cnt != 2'd2) cnt <= cnt + 2'd1;
      end
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_req |=> !flag_req); // R4
  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pswp |=> pswp); // R7
  AST_PERM_VIA_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pswp) |-> (flag_req && flag_op == OP_SETP)); // R4
  AST_REV_VIA_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rswp) |-> flag_req); // R4
  AST_UPPER_ONLY_WP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_prot && tgt_addr[ADDR_W-1]) |-> wp_lat); // R6
  AST_ACK_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (kind != K_IDLE)); // R1
  AST_WP_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !dev_valid && !stop_evt && wp_eff && cnt != 2'd0) |=> !data_ack); // R5
endmodule

// File: tb/tb_wp_guard.sv
module tb_wp_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dev_valid = 0, a0_hv = 0, wp_pin = 0, wp_sample = 0, byte_done = 0, stop_evt = 0;
  logic [7:0] dev_byte = 8'h00, tgt_addr = 8'h00;
  logic [2:0] strap = 3'b000;
  logic dev_ack, data_ack, flag_req, addr_prot;
  logic [1:0] flag_op;
  int checks = 0, errors = 0;
  bit e_p = 0, e_r = 0, done = 0;

  always #4 clk = ~clk;

  wp_guard dut (.clk(clk), .rst_n(rst_n), .dev_valid(dev_valid), .dev_byte(dev_byte),
    .strap(strap), .a0_hv(a0_hv), .wp_pin(wp_pin), .wp_sample(wp_sample),
    .byte_done(byte_done), .stop_evt(stop_evt), .tgt_addr(tgt_addr),
    .dev_ack(dev_ack), .data_ack(data_ack), .flag_req(flag_req), .flag_op(flag_op),
    .addr_prot(addr_prot));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic bit exp_dev(input [7:0] b, input [2:0] s, input bit hv);
    if (b[7:4] == 4'b1010) return b[3:1] == s;
    if (b[7:4] != 4'b0110) return 0;
    if (hv) begin
      if (s[2] || b[3:1] != {s[2:1], 1'b1}) return 0;
      return b[0] ? !e_r : 1'b1;
    end
    return (b[3:1] == s) && !e_p;
  endfunction

  task automatic dev(input [7:0] b, input bit exp, input string tag);
    @(negedge clk); dev_valid = 1; dev_byte = b;
    @(negedge clk); dev_valid = 0;
    chk(dev_ack, exp, tag);
  endtask

  task automatic byt(input bit exp, input string tag);
    @(negedge clk); byte_done = 1;
    @(negedge clk); byte_done = 0;
    chk(data_ack, exp, tag);
  endtask

  task automatic wps(input bit lvl);
    @(negedge clk); wp_pin = lvl; wp_sample = 1;
    @(negedge clk); wp_sample = 0;
  endtask

  task automatic stp(input bit req, input [1:0] op, input string tag);
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
    chk(flag_req, req, tag);
    if (req) chk(flag_op, op, tag);
  endtask

  task automatic sweep_dev(input string tag);
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 8; s++)
        for (int b = 0; b < 256; b++) begin
          strap = s[2:0]; a0_hv = h[0];
          dev(b[7:0], exp_dev(b[7:0], s[2:0], h[0]), tag);
          stp(0, 2'b00, tag);
        end
    a0_hv = 0;
  endtask

  task automatic sweep_prot(input bit wpl, input string tag);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); tgt_addr = a[7:0];
      #1 chk(addr_prot, wpl || ((e_p || e_r) && !a[7]), tag);
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dev_ack, 0, "R10"); chk(data_ack, 0, "R10");
    chk(flag_req, 0, "R10"); chk(addr_prot, 0, "R10");
    rst_n = 1;
    @(negedge clk);
    chk(addr_prot, 0, "R10");

    sweep_dev("R1 R2 R3 clear");
    sweep_prot(0, "R6 clear");

    // reversible set rejected by WP
    strap = 3'b000; a0_hv = 1;
    dev(8'h62, 1, "R3");
    byt(1, "R9 addr");
    wps(1);
    byt(0, "R5");
    stp(0, 2'b00, "R5");
    wp_pin = 0;
    dev(8'h63, 1, "R5 flag unchanged");
    stp(0, 2'b00, "R5");

    // reversible set accepted
    dev(8'h62, 1, "R3");
    byt(1, "R9");
    wps(0);
    byt(1, "R4");
    byt(0, "R9 extra byte");
    stp(1, 2'b01, "R4");
    e_r = 1;
    sweep_dev("R1 R2 R3 rev set");
    sweep_prot(0, "R6 rev set");

    // clear with HV lost mid-command
    strap = 3'b010; a0_hv = 1;
    dev(8'h66, 1, "R3 clear");
    byt(1, "R9");
    a0_hv = 0;
    @(negedge clk);
    a0_hv = 1;
    wps(0);
    byt(1, "R8");
    stp(0, 2'b00, "R8");
    dev(8'h67, 0, "R8 flag kept");
    stp(0, 2'b00, "R8");

    // clear accepted
    dev(8'h66, 1, "R3 clear");
    byt(1, "R9"); wps(0); byt(1, "R4");
    stp(1, 2'b10, "R4");
    e_r = 0;
    dev(8'h67, 1, "R4 cleared");
    stp(0, 2'b00, "R4");
    sweep_prot(0, "R6 cleared");

    // permanent set
    strap = 3'b101; a0_hv = 0;
    dev(8'h6A, 1, "R2");
    byt(1, "R9"); wps(0); byt(1, "R4");
    stp(1, 2'b00, "R4");
    e_p = 1;
    dev(8'h6A, 0, "R7 second set");
    stp(0, 2'b00, "R7");
    dev(8'h6B, 0, "R2 read set");
    stp(0, 2'b00, "R2");

    // clearing the reversible flag leaves permanent protection
    strap = 3'b010; a0_hv = 1;
    dev(8'h66, 1, "R7");
    byt(1, "R9"); wps(0); byt(1, "R7");
    stp(1, 2'b10, "R7");
    a0_hv = 0;
    sweep_prot(0, "R7 R6 perm");
    sweep_dev("R1 R2 R3 perm set");

    // memory writes with WP
    strap = 3'b011;
    dev(8'hA6, 1, "R1");
    byt(1, "R9 addr");
    wps(1);
    sweep_prot(1, "R6 wp");
    byt(0, "R5 mem");
    stp(0, 2'b00, "R5");
    wp_pin = 0;
    dev(8'hA6, 1, "R1");
    byt(1, "R9"); wps(0);
    byt(1, "R9 mem data"); byt(1, "R9 mem data"); byt(1, "R9 mem data");
    stp(0, 2'b00, "R9");

    finish_run();
  end
endmodule